// File: doc/BRIEF.md
# Multi-Match Ternary Lookup Array with Result Streaming

This block is a small ternary associative array. Each slot keeps a binary value word, a per-bit wildcard mask and a data reference. A search presents a key together with a query mask. The whole array is compared in parallel. The block then returns the matching slots as a back-pressured result stream instead of reporting only the winner of a priority encoder. Wildcards work on both sides of the compare. A set stored mask bit makes that slot indifferent to the key bit. A set query mask bit makes the search indifferent to it. This lets one search pull out a whole subspace of key space, for example every key that shares its upper bits.

Each search selects one of two modes. In the all-hits mode every matching slot is returned in ascending index order, one per cycle while the consumer is ready, and the final beat carries a last flag. In the first-hit mode only the lowest-index match is returned, which gives the classic priority result. A search with no match produces a single beat that is flagged as empty. A write port can store a slot, invalidate it, or release it. Releasing a slot raises a reserved flag bit in its value so that a ternary search on that one bit finds reclaimable slots. The search and write ports are both refused while a result stream is in flight.

Top module: `tcam_stream`

## Requirements
- R1: A slot matches a key when every key bit whose stored mask bit is 0 (and whose query mask bit is 0) equals the stored value bit. Key bits under a stored mask bit of 1 never affect the match.
- R2: A query mask bit of 1 removes that key position from the compare for every slot, so a low-k-bit query mask retrieves all slots in the aligned block of 2^k keys.
- R3: A slot whose valid flag is clear never matches, whatever its value and mask hold. After reset all slots are invalid. Write opcode 1 clears the valid flag of the addressed slot.
- R4: With srch_first=0 the stream returns every matching slot exactly once, in strictly ascending index order, with at most one beat per cycle. res_last is 1 on the final beat only. res_valid goes high in the cycle after the search is accepted and is low again after the last beat's handshake.
- R5: With srch_first=1 the stream holds exactly one beat: the lowest-index matching slot, with res_last=1.
- R6: A search that matches no slot returns one beat with res_none=1, res_last=1 and res_index=0.
- R7: Every hit beat carries the slot's index, stored value, stored mask and data reference.
- R8: While res_valid=1 and res_ready=0, the beat on the result outputs stays unchanged in the next cycle.
- R9: srch_ready and wr_ready are 1 whenever no stream is in progress. Both are 0 from the cycle after a search is accepted until the last beat's handshake. A write held during a stream is not applied until the stream has ended.
- R10: Write opcode 0 stores value, mask and reference and sets the slot valid. Opcode 2 (release) sets the reserved flag bit (bit FREE_BIT, default the MSB) of the stored value to 1, clears that bit of the stored mask, and sets the slot valid; the other fields are kept. Opcode 3 changes nothing.
- R11: A search accepted in the same cycle as a write sees the array contents from before that write.
- R12: During and right after reset, res_valid=0, srch_ready=1 and wr_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_op | input | 2 | 0 store, 1 invalidate, 2 release, 3 no operation |
| wr_index | input | IDX_W | Addressed slot |
| wr_value | input | KEY_W | Value to store |
| wr_mask | input | KEY_W | Stored wildcard mask, 1 = don't care |
| wr_ref | input | REF_W | Data reference to store |
| srch_valid | input | 1 | Search request |
| srch_ready | output | 1 | Search accepted when high with srch_valid |
| srch_key | input | KEY_W | Search key |
| srch_qmask | input | KEY_W | Query wildcard mask, 1 = don't care |
| srch_first | input | 1 | 1 = return only the lowest-index hit |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer accepts the beat |
| res_index | output | IDX_W | Index of the hit slot |
| res_value | output | KEY_W | Stored value of the hit slot |
| res_mask | output | KEY_W | Stored mask of the hit slot |
| res_ref | output | REF_W | Data reference of the hit slot |
| res_last | output | 1 | Final beat of this search |
| res_none | output | 1 | Search matched nothing |

## Verification
The bench fills the array with slots whose masks grow from none to all bits and sweeps every key value under several query masks in both modes. A compare that inverted a mask's sense, or ignored the query mask, would return the wrong set of indices. The streams run under random back-pressure. A sequencer that cleared a bit on a stalled cycle would skip a hit, and one that mis-detected the last beat would end early or repeat an index. The bench also drives the cases where a write collides with a search: a write in the same cycle as a search would, if applied first, change the hit list, and a write that slipped past the stall would remove a slot in the middle of its own stream. A release that set the wrong bit would hide the slot from the free-slot search.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

   typedef enum logic [1:0] {
      TC_STORE   = 2'd0,
      TC_CLEAR   = 2'd1,
      TC_RELEASE = 2'd2,
      TC_NOP     = 2'd3
   } tc_op_e;

endpackage

// File: rtl/tcam_slots.sv
module tcam_slots
   import tcam_pkg::*;
#(
   parameter int KEY_W    = 8,
   parameter int DEPTH    = 8,
   parameter int REF_W    = 8,
   parameter int FREE_BIT = KEY_W - 1,
   parameter bit FREE_EN  = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       op,
   input  logic [IDX_W-1:0] idx,
   input  logic [KEY_W-1:0] val,
   input  logic [KEY_W-1:0] msk,
   input  logic [REF_W-1:0] rref,
   output logic             ent_vld [DEPTH],
   output logic [KEY_W-1:0] ent_val [DEPTH],
   output logic [KEY_W-1:0] ent_msk [DEPTH],
   output logic [REF_W-1:0] ent_ref [DEPTH]
);

   localparam logic [KEY_W-1:0] FLAG_ONE = KEY_W'(1) << FREE_BIT;

   tc_op_e op_e;
   assign op_e = tc_op_e'(op);

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);

      logic             vld_r;
      logic [KEY_W-1:0] val_r;
      logic [KEY_W-1:0] msk_r;
      logic [REF_W-1:0] ref_r;
      logic             sel;
      logic             rel_take;
      logic [KEY_W-1:0] rel_val;
      logic [KEY_W-1:0] rel_msk;

      assign sel = we && (idx == SLOT);

      if (FREE_EN) begin : g_rel
         assign rel_take = 1'b1;
         assign rel_val  = val_r | FLAG_ONE;
         assign rel_msk  = msk_r & ~FLAG_ONE;
      end else begin : g_norel
         assign rel_take = 1'b0;
         assign rel_val  = val_r;
         assign rel_msk  = msk_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_r <= 1'b0;
            val_r <= '0;
            msk_r <= '0;
            ref_r <= '0;
         end else if (sel) begin
            case (op_e)
               TC_STORE: begin
                  vld_r <= 1'b1;
                  val_r <= val;
                  msk_r <= msk;
                  ref_r <= rref;
               end
               TC_CLEAR: vld_r <= 1'b0;
               TC_RELEASE: begin
                  if (rel_take) begin
                     vld_r <= 1'b1;
                     val_r <= rel_val;
                     msk_r <= rel_msk;
                  end
               end
               default: ;
            endcase
         end
      end

      assign ent_vld[e] = vld_r;
      assign ent_val[e] = val_r;
      assign ent_msk[e] = msk_r;
      assign ent_ref[e] = ref_r;

      // R3: an invalidate leaves the slot without its valid flag
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && op_e == TC_CLEAR) |=> !vld_r);

      if (FREE_EN) begin : g_rel_chk
         // R10: a release leaves the slot valid with the flag bit exact-set
         a_r10_release_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && op_e == TC_RELEASE) |=> (vld_r && val_r[FREE_BIT] && !msk_r[FREE_BIT]));
      end
   end

endmodule

// File: rtl/tcam_compare.sv
module tcam_compare #(
   parameter int KEY_W = 8,
   parameter int DEPTH = 8
) (
   input  logic             ent_vld [DEPTH],
   input  logic [KEY_W-1:0] ent_val [DEPTH],
   input  logic [KEY_W-1:0] ent_msk [DEPTH],
   input  logic [KEY_W-1:0] key,
   input  logic [KEY_W-1:0] qmask,
   output logic [DEPTH-1:0] hit
);

   for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      logic [KEY_W-1:0] diff;
      assign diff   = (ent_val[e] ^ key) & ~ent_msk[e] & ~qmask;
      assign hit[e] = ent_vld[e] && (diff == '0);
   end

endmodule

// File: rtl/tcam_hitseq.sv
module tcam_hitseq #(
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEPTH-1:0] match_vec,
   input  logic             first_only,
   input  logic             out_ready,
   output logic             busy,
   output logic [IDX_W-1:0] cur_idx,
   output logic             cur_last,
   output logic             cur_none
);

   logic             busy_q;
   logic             first_q;
   logic [DEPTH-1:0] pend_q;
   logic [DEPTH-1:0] rest;
   logic             fire;

   assign rest     = pend_q & (pend_q - DEPTH'(1));
   assign busy     = busy_q;
   assign cur_none = busy_q && (pend_q == '0);
   assign cur_last = first_q || cur_none || (rest == '0);
   assign fire     = busy_q && out_ready;

   always_comb begin
      cur_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (pend_q[i]) cur_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         first_q <= 1'b0;
         pend_q  <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         first_q <= first_only;
         pend_q  <= match_vec;
      end else if (fire) begin
         if (cur_last) begin
            busy_q <= 1'b0;
            pend_q <= '0;
         end else begin
            pend_q <= rest;
         end
      end
   end

   // R8: a refused beat stays in place
   a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !out_ready) |=> (busy_q && $stable(cur_idx) && $stable(cur_last)));

   // R4: successive beats of one stream climb in index
   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && out_ready && !cur_last) |=> (busy_q && cur_idx > $past(cur_idx)));

   // R4: a new search is not taken while a stream runs
   a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !start);

endmodule

// File: rtl/tcam_stream.sv
module tcam_stream #(
   parameter int KEY_W    = 8,
   parameter int DEPTH    = 8,
   parameter int REF_W    = 8,
   parameter int FREE_BIT = KEY_W - 1,
   parameter bit FREE_EN  = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [1:0]       wr_op,
   input  logic [IDX_W-1:0] wr_index,
   input  logic [KEY_W-1:0] wr_value,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic [REF_W-1:0] wr_ref,
   input  logic             srch_valid,
   output logic             srch_ready,
   input  logic [KEY_W-1:0] srch_key,
   input  logic [KEY_W-1:0] srch_qmask,
   input  logic             srch_first,
   output logic             res_valid,
   input  logic             res_ready,
   output logic [IDX_W-1:0] res_index,
   output logic [KEY_W-1:0] res_value,
   output logic [KEY_W-1:0] res_mask,
   output logic [REF_W-1:0] res_ref,
   output logic             res_last,
   output logic             res_none
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tcam_stream: DEPTH must be at least 2");
   end
   if (KEY_W < 1 || REF_W < 1) begin : g_bad_width
      $error("tcam_stream: KEY_W and REF_W must be positive");
   end
   if (FREE_BIT < 0 || FREE_BIT >= KEY_W) begin : g_bad_flag
      $error("tcam_stream: FREE_BIT must lie inside the key");
   end

   logic             ent_vld [DEPTH];
   logic [KEY_W-1:0] ent_val [DEPTH];
   logic [KEY_W-1:0] ent_msk [DEPTH];
   logic [REF_W-1:0] ent_ref [DEPTH];
   logic [DEPTH-1:0] hit_vec;
   logic             busy;
   logic             wr_fire;
   logic             srch_fire;
   logic [IDX_W-1:0] cur_idx;
   logic             cur_last;
   logic             cur_none;

   assign wr_ready   = !busy;
   assign srch_ready = !busy;
   assign wr_fire    = wr_valid && wr_ready;
   assign srch_fire  = srch_valid && srch_ready;

   tcam_slots #(
      .KEY_W(KEY_W), .DEPTH(DEPTH), .REF_W(REF_W),
      .FREE_BIT(FREE_BIT), .FREE_EN(FREE_EN)
   ) u_slots (
      .clk(clk), .rst_n(rst_n),
      .we(wr_fire), .op(wr_op), .idx(wr_index),
      .val(wr_value), .msk(wr_mask), .rref(wr_ref),
      .ent_vld(ent_vld), .ent_val(ent_val),
      .ent_msk(ent_msk), .ent_ref(ent_ref)
   );

   tcam_compare #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_cmp (
      .ent_vld(ent_vld), .ent_val(ent_val), .ent_msk(ent_msk),
      .key(srch_key), .qmask(srch_qmask), .hit(hit_vec)
   );

   tcam_hitseq #(.DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(srch_fire), .match_vec(hit_vec), .first_only(srch_first),
      .out_ready(res_ready), .busy(busy),
      .cur_idx(cur_idx), .cur_last(cur_last), .cur_none(cur_none)
   );

   assign res_valid = busy;
   assign res_index = cur_idx;
   assign res_last  = cur_last;
   assign res_none  = cur_none;
   assign res_value = cur_none ? '0 : ent_val[cur_idx];
   assign res_mask  = cur_none ? '0 : ent_msk[cur_idx];
   assign res_ref   = cur_none ? '0 : ent_ref[cur_idx];

   // R6: an empty result is always the closing beat
   a_r6_none_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_none) |-> (res_last && res_index == '0));

   // R3: a reported hit points at a slot that is still valid
   a_r3_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_none) |-> ent_vld[res_index]);

   // R9: an accepted search opens a stream in the next cycle
   a_r9_stream_opens: assert property (@(posedge clk) disable iff (!rst_n)
      srch_fire |=> (res_valid && !srch_ready && !wr_ready));

   // R9: slot contents do not move while a stream is being read out
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(res_valid) && !res_none) |-> $stable(ent_vld[res_index]));

endmodule

// File: tb/tb_tcam_stream.sv
`timescale 1ns/1ps
module tb_tcam_stream;

   localparam int KW = 8;
   localparam int DP = 8;
   localparam int RW = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic          wr_ready;
   logic [1:0]    wr_op = 2'd0;
   logic [IW-1:0] wr_index = '0;
   logic [KW-1:0] wr_value = '0;
   logic [KW-1:0] wr_mask = '0;
   logic [RW-1:0] wr_ref = '0;
   logic          srch_valid = 1'b0;
   logic          srch_ready;
   logic [KW-1:0] srch_key = '0;
   logic [KW-1:0] srch_qmask = '0;
   logic          srch_first = 1'b0;
   logic          res_valid;
   logic          res_ready = 1'b0;
   logic [IW-1:0] res_index;
   logic [KW-1:0] res_value;
   logic [KW-1:0] res_mask;
   logic [RW-1:0] res_ref;
   logic          res_last;
   logic          res_none;

   int checks = 0;
   int failures = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [KW-1:0] m_val [DP];
   logic [KW-1:0] m_msk [DP];
   logic [RW-1:0] m_ref [DP];
   bit            m_vld [DP];

   always #2.5 clk = ~clk;

   tcam_stream dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_op(wr_op),
      .wr_index(wr_index), .wr_value(wr_value), .wr_mask(wr_mask), .wr_ref(wr_ref),
      .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
      .srch_qmask(srch_qmask), .srch_first(srch_first),
      .res_valid(res_valid), .res_ready(res_ready), .res_index(res_index),
      .res_value(res_value), .res_mask(res_mask), .res_ref(res_ref),
      .res_last(res_last), .res_none(res_none)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit mdl_hit(int i, logic [KW-1:0] key, logic [KW-1:0] qm);
      return m_vld[i] && (((m_val[i] ^ key) & ~m_msk[i] & ~qm) == '0);
   endfunction

   task automatic mdl_write(input logic [1:0] op, input int idx, input logic [KW-1:0] v,
                            input logic [KW-1:0] m, input logic [RW-1:0] r);
      case (op)
         2'd0: begin m_vld[idx] = 1; m_val[idx] = v; m_msk[idx] = m; m_ref[idx] = r; end
         2'd1: m_vld[idx] = 0;
         2'd2: begin m_vld[idx] = 1; m_val[idx][KW-1] = 1'b1; m_msk[idx][KW-1] = 1'b0; end
         default: ;
      endcase
   endtask

   task automatic do_write(input logic [1:0] op, input int idx, input logic [KW-1:0] v,
                           input logic [KW-1:0] m, input logic [RW-1:0] r);
      @(negedge clk);
      chk(wr_ready == 1'b1, "R9", "wr_ready idle", 32'(wr_ready), 1);
      wr_valid = 1; wr_op = op; wr_index = IW'(idx); wr_value = v; wr_mask = m; wr_ref = r;
      @(negedge clk);
      wr_valid = 0;
      mdl_write(op, idx, v, m, r);
   endtask

   // wmode: 0 none, 1 write in the same cycle as the search, 2 write held during stream
   task automatic do_search(input logic [KW-1:0] key, input logic [KW-1:0] qm,
                            input bit first, input bit stall, input int wmode,
                            input logic [1:0] wop, input int widx, input logic [KW-1:0] wv,
                            input logic [KW-1:0] wm, input logic [RW-1:0] wrf,
                            input string tag);
      int exp_idx [DP];
      int n = 0;
      int nexp;
      int k = 0;
      bit done = 0;
      bit have_prev = 0;
      logic [IW-1:0] prev_idx = '0;
      bit rdy;
      for (int i = 0; i < DP; i++) begin
         if (mdl_hit(i, key, qm)) begin exp_idx[n] = i; n++; end
      end
      nexp = (n == 0 || first) ? 1 : n;
      @(negedge clk);
      chk(srch_ready == 1'b1, "R9", "srch_ready idle", 32'(srch_ready), 1);
      srch_valid = 1; srch_key = key; srch_qmask = qm; srch_first = first;
      if (wmode == 1) begin
         wr_valid = 1; wr_op = wop; wr_index = IW'(widx); wr_value = wv; wr_mask = wm; wr_ref = wrf;
      end
      @(negedge clk);
      srch_valid = 0;
      if (wmode == 1) begin
         wr_valid = 0;
         mdl_write(wop, widx, wv, wm, wrf);
      end
      if (wmode == 2) begin
         wr_valid = 1; wr_op = wop; wr_index = IW'(widx); wr_value = wv; wr_mask = wm; wr_ref = wrf;
      end
      while (!done) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rdy = !stall || (lfsr[1:0] != 2'b00);
         res_ready = rdy;
         chk(res_valid == 1'b1, "R4", "res_valid in stream", 32'(res_valid), 1);
         chk(!srch_ready && !wr_ready, "R9", "ready low in stream",
             32'({srch_ready, wr_ready}), 0);
         if (have_prev)
            chk(res_index == prev_idx, "R8", "held index", 32'(res_index), 32'(prev_idx));
         if (n == 0) begin
            chk(res_none && res_last, "R6", "none/last", 32'({res_none, res_last}), 3);
            chk(res_index == '0, "R6", "none index", 32'(res_index), 0);
         end else begin
            chk(!res_none, tag, "none flag on hit", 32'(res_none), 0);
            chk(res_index == IW'(exp_idx[k]), tag, "hit index", 32'(res_index), 32'(exp_idx[k]));
            chk(res_value == m_val[exp_idx[k]], "R7", "value", 32'(res_value), 32'(m_val[exp_idx[k]]));
            chk(res_mask == m_msk[exp_idx[k]], "R7", "mask", 32'(res_mask), 32'(m_msk[exp_idx[k]]));
            chk(res_ref == m_ref[exp_idx[k]], "R7", "ref", 32'(res_ref), 32'(m_ref[exp_idx[k]]));
            chk(res_last == (k == nexp - 1), first ? "R5" : "R4", "last flag",
                32'(res_last), 32'(k == nexp - 1));
         end
         if (rdy) begin
            k++;
            have_prev = 0;
            if (k == nexp) done = 1;
         end else begin
            have_prev = 1;
            prev_idx = res_index;
         end
         @(negedge clk);
      end
      res_ready = 0;
      chk(res_valid == 1'b0, "R4", "stream closed", 32'(res_valid), 0);
      chk(srch_ready == 1'b1, "R9", "srch_ready after stream", 32'(srch_ready), 1);
      if (wmode == 2) begin
         chk(wr_ready == 1'b1, "R9", "wr_ready after stream", 32'(wr_ready), 1);
         @(negedge clk);
         wr_valid = 0;
         mdl_write(wop, widx, wv, wm, wrf);
      end
   endtask

   task automatic plain(input logic [KW-1:0] key, input logic [KW-1:0] qm,
                        input bit first, input bit stall, input string tag);
      do_search(key, qm, first, stall, 0, 2'd0, 0, '0, '0, '0, tag);
   endtask

   function automatic logic [KW-1:0] fill_mask(int i);
      if (i == DP - 1) return 8'hFF;
      case (i % 4)
         0: return 8'h00;
         1: return 8'h03;
         2: return 8'h0F;
         default: return 8'h3C;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < DP; i++) begin
         m_vld[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_ref[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0, "R12", "res_valid in reset", 32'(res_valid), 0);
      chk(srch_ready && wr_ready, "R12", "ready in reset", 32'({srch_ready, wr_ready}), 3);
      rst_n = 1;
      @(negedge clk);
      chk(res_valid == 1'b0, "R12", "res_valid after reset", 32'(res_valid), 0);
      chk(srch_ready && wr_ready, "R12", "ready after reset", 32'({srch_ready, wr_ready}), 3);

      // empty array: nothing matches, even with the whole key wildcarded
      plain(8'h00, 8'hFF, 0, 0, "R3");
      plain(8'h5A, 8'h00, 1, 0, "R3");

      for (int i = 0; i < DP; i++)
         do_write(2'd0, i, KW'(i * 53 + 17), fill_mask(i), RW'(8'hA0 + i));

      // R1: every key, exact query, all-hit mode with random stalls
      for (int key = 0; key < 256; key++) plain(KW'(key), 8'h00, 0, key[0], "R1");
      // R5: every key, first-hit mode
      for (int key = 0; key < 256; key++) plain(KW'(key), 8'h00, 1, key[1], "R5");
      // R2: low-k query wildcards and a scattered query mask
      for (int kb = 0; kb <= KW; kb++) begin
         for (int key = 0; key < 256; key += 23)
            plain(KW'(key), KW'((9'd1 << kb) - 9'd1), kb[0], 1, "R2");
      end
      for (int key = 0; key < 256; key += 5) plain(KW'(key), 8'hA5, 0, 1, "R2");

      // R11: write issued with the search; stream reflects the old slot 0
      do_search(m_val[0], 8'h00, 0, 0, 1, 2'd0, 0, ~m_val[0], 8'h00, 8'h11, "R11");
      plain(m_val[0], 8'h00, 0, 0, "R11");
      plain(~m_val[0], 8'h00, 0, 0, "R11");

      // R9: invalidate held during a stream that lists slot 3
      do_search(8'h00, 8'hFF, 0, 1, 2, 2'd1, 3, '0, '0, '0, "R9");
      plain(8'h00, 8'hFF, 0, 0, "R9");

      // R3: invalidate slot 5 and the all-wildcard slot 7
      do_write(2'd1, 5, '0, '0, '0);
      do_write(2'd1, 7, '0, '0, '0);
      for (int key = 0; key < 256; key++) plain(KW'(key), 8'h00, key[2], key[0], "R3");

      // R10: release slots 1 and 6, opcode 3 on slot 4, then hunt free slots
      do_write(2'd2, 1, 8'h00, 8'hFF, 8'hEE);
      do_write(2'd2, 6, 8'h00, 8'hFF, 8'hEE);
      do_write(2'd3, 4, 8'h77, 8'h55, 8'h33);
      plain(8'h80, 8'h7F, 0, 1, "R10");
      plain(8'h80, 8'h7F, 1, 0, "R10");
      for (int key = 0; key < 256; key++) plain(KW'(key), 8'h00, 0, key[0], "R10");
      do_write(2'd0, 5, 8'h80, 8'h7F, 8'h55);
      plain(8'h80, 8'h7F, 0, 1, "R10");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule